// File: doc/BRIEF.md
# Over-Temperature Alarm Comparator

This block watches a stream of signed temperature samples and turns them into a single alarm line. A sample is considered only in the cycle where the conversion-done strobe is high. A sample counts as a fault when it lies beyond the threshold the block is currently watching. Only a configurable run of consecutive faults is allowed to act, which filters out isolated noisy readings. The alarm state drives an output pin whose active level is selectable, so the pin can feed an open-drain pad enable.

Two operating styles are offered. In thermostat style the alarm switches on above the upper threshold and off below the lower one. In latching style an upper crossing raises the alarm. The alarm then stays raised until any register read, signalled by a read strobe, drops it. After each clear the watched threshold swaps, so the next event must be a fall below the lower threshold, and the clear after that watches the upper threshold again. A sleep control stops the evaluation of samples. Sleep drops a latched alarm but leaves a thermostat alarm untouched.

Top module: `ot_alarm`

## Requirements
- R1: After synchronous reset `alarm_active` is 0, the fault run count is zero, the upper threshold is watched, and with `cfg_polarity` = 0 `alarm_pin` is 1.
- R2: `cfg_queue` selects the number of consecutive qualifying samples needed to act: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4, 2'b11 needs 6.
- R3: A sample strobed by `conv_done` that does not qualify resets the run count to zero. After the run reaches its length and acts, the count restarts from zero.
- R4: With `cfg_mode` = 0 (thermostat), an inactive alarm is raised by samples strictly greater than `thr_hi`. An active alarm is dropped by samples strictly less than `thr_lo`. All values are compared as signed 9-bit two's complement numbers.
- R5: With `cfg_mode` = 1 (latching), a completed run raises the alarm. The alarm then stays raised, with samples ignored, until a cycle with `rd_strobe` high, after which it is 0.
- R6: In latching mode every clear toggles the watched threshold. After the first clear only samples below `thr_lo` can raise the alarm, and the clear after that returns to watching `thr_hi`.
- R7: In thermostat mode `rd_strobe` has no effect on the alarm.
- R8: `alarm_pin` equals `alarm_active` when `cfg_polarity` = 1 and its inverse when `cfg_polarity` = 0.
- R9: While `cfg_shutdown` = 1 samples are ignored and the run count is held at zero. In latching mode sleep clears a raised alarm, and this clear toggles the watched threshold like a read. In thermostat mode sleep leaves the alarm unchanged.
- R10: In any cycle where `cfg_mode` or `cfg_queue` differs from its value in the previous cycle, the run count resets to zero, the upper threshold becomes watched, and a sample strobed in that cycle is ignored. The alarm level is kept.
- R11: In latching mode with the alarm raised, a cycle with both `rd_strobe` and `conv_done` high clears the alarm, and that cycle's sample is not counted.
- R12: `alarm_active` changes only on the clock edge that follows a cycle with `conv_done`, `rd_strobe` or `cfg_shutdown` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | Conversion finished; `sample` is valid this cycle |
| sample | input | TEMP_W | Signed temperature, 0.5 degree step |
| thr_hi | input | TEMP_W | Signed upper (over-temperature) threshold |
| thr_lo | input | TEMP_W | Signed lower (hysteresis) threshold |
| cfg_shutdown | input | 1 | Sleep: stop evaluating samples |
| cfg_mode | input | 1 | 0 thermostat, 1 latching |
| cfg_polarity | input | 1 | 0 pin active low, 1 pin active high |
| cfg_queue | input | 2 | Consecutive-fault run length select |
| rd_strobe | input | 1 | Any register read happened this cycle |
| alarm_pin | output | 1 | Alarm at the chosen pin polarity |
| alarm_active | output | 1 | Internal alarm state, 1 when raised |

## Verification
The clearing of a latched alarm and the counting of a fresh sample can land in the same cycle. The bench provokes this by raising `rd_strobe` and `conv_done` together, or by entering sleep on a sample cycle. The sample used there qualifies for the newly watched threshold, so the result shows whether the sample leaked into the run. A configuration change coinciding with a sample is provoked as well. Every cycle is judged against a behavioural reference model, and directed expectations check the absolute alarm value at the key points.

// File: rtl/ot_alarm_pkg.sv
package ot_alarm_pkg;

    localparam int QSEL_W = 2;

    typedef enum logic {
        MODE_THERMO = 1'b0,
        MODE_LATCH  = 1'b1
    } alarm_mode_e;

    typedef enum logic {
        WATCH_UPPER = 1'b0,
        WATCH_LOWER = 1'b1
    } watch_dir_e;

    typedef struct packed {
        logic              sleep;
        alarm_mode_e       mode;
        logic [QSEL_W-1:0] qsel;
    } ctl_t;

    // run length demanded by each queue select code
    function automatic int unsigned fault_need(input logic [QSEL_W-1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/ot_fault_queue.sv
module ot_fault_queue #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             qualify,
    input  logic             clear,
    input  logic [CNT_W-1:0] need,
    output logic             trip
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_inc;
    logic             full;

    assign run_inc = {1'b0, run_q} + 1'b1;
    assign full    = run_inc >= {1'b0, need};
    assign trip    = count_en & qualify & full & ~clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (count_en) begin
            if (!qualify || full) run_q <= '0;
            else                  run_q <= run_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/ot_alarm_state.sv
module ot_alarm_state
    import ot_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  alarm_mode_e mode,
    input  logic        sleep,
    input  logic        rd,
    input  logic        trip,
    input  logic        cfg_chg,
    output logic        alarm,
    output watch_dir_e  dir
);
    logic       clear_evt;
    logic       alarm_d;
    watch_dir_e dir_d;

    assign clear_evt = (mode == MODE_LATCH) & alarm & (sleep | rd);

    always_comb begin
        alarm_d = alarm;
        dir_d   = dir;
        if (clear_evt) begin
            alarm_d = 1'b0;
            dir_d   = (dir == WATCH_UPPER) ? WATCH_LOWER : WATCH_UPPER;
        end else if (trip) begin
            alarm_d = (mode == MODE_LATCH) ? 1'b1 : ~alarm;
        end
        if (cfg_chg) dir_d = WATCH_UPPER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
            dir   <= WATCH_UPPER;
        end else begin
            alarm <= alarm_d;
            dir   <= dir_d;
        end
    end
endmodule

// File: rtl/ot_alarm.sv
module ot_alarm
    import ot_alarm_pkg::*;
#(
    parameter int TEMP_W = 9,
    parameter int CNT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     conv_done,
    input  logic signed [TEMP_W-1:0] sample,
    input  logic signed [TEMP_W-1:0] thr_hi,
    input  logic signed [TEMP_W-1:0] thr_lo,
    input  logic                     cfg_shutdown,
    input  logic                     cfg_mode,
    input  logic                     cfg_polarity,
    input  logic [QSEL_W-1:0]        cfg_queue,
    input  logic                     rd_strobe,
    output logic                     alarm_pin,
    output logic                     alarm_active
);
    ctl_t             ctl, ctl_q;
    logic             cfg_chg;
    logic             above, below, watch_low, qualify;
    logic             latched_hold, count_en, count_clr, trip;
    logic [CNT_W-1:0] need;
    watch_dir_e       dir;

    assign ctl.sleep = cfg_shutdown;
    assign ctl.mode  = alarm_mode_e'(cfg_mode);
    assign ctl.qsel  = cfg_queue;

    // previous mode and queue select, to spot a reconfiguration
    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl;
    end

    assign cfg_chg = (ctl.mode != ctl_q.mode) || (ctl.qsel != ctl_q.qsel);
    assign need    = CNT_W'(fault_need(ctl.qsel));

    assign above     = sample > thr_hi;
    assign below     = sample < thr_lo;
    assign watch_low = (ctl.mode == MODE_LATCH) ? (dir == WATCH_LOWER) : alarm_active;
    assign qualify   = watch_low ? below : above;

    assign latched_hold = (ctl.mode == MODE_LATCH) & alarm_active;
    assign count_clr    = ctl.sleep | cfg_chg | latched_hold;
    assign count_en     = conv_done & ~count_clr;

    ot_fault_queue #(.CNT_W(CNT_W)) queue_i (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .qualify  (qualify),
        .clear    (count_clr),
        .need     (need),
        .trip     (trip)
    );

    ot_alarm_state state_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (ctl.mode),
        .sleep   (ctl.sleep),
        .rd      (rd_strobe),
        .trip    (trip),
        .cfg_chg (cfg_chg),
        .alarm   (alarm_active),
        .dir     (dir)
    );

    assign alarm_pin = cfg_polarity ? alarm_active : ~alarm_active;
endmodule

// File: rtl/ot_alarm_chk.sv
module ot_alarm_chk (
    input logic clk,
    input logic rst,
    input logic conv_done,
    input logic rd_strobe,
    input logic cfg_shutdown,
    input logic cfg_mode,
    input logic alarm_active
);
    // R12
    quiet_cycle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !rd_strobe && !cfg_shutdown) |=> $stable(alarm_active));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && alarm_active && !rd_strobe && !cfg_shutdown) |=> alarm_active);

    // R5
    latch_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && alarm_active && rd_strobe) |=> !alarm_active);

    // R9
    latch_sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && alarm_active && cfg_shutdown) |=> !alarm_active);

    // R9
    thermo_sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && cfg_shutdown) |=> $stable(alarm_active));

    // R7
    thermo_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && !conv_done) |=> $stable(alarm_active));
endmodule

bind ot_alarm ot_alarm_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .conv_done    (conv_done),
    .rd_strobe    (rd_strobe),
    .cfg_shutdown (cfg_shutdown),
    .cfg_mode     (cfg_mode),
    .alarm_active (alarm_active)
);

// File: tb/ot_alarm_tb_top.sv
module ot_alarm_tb_top;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             conv_done = 1'b0;
    logic signed [8:0] sample = '0;
    logic signed [8:0] thr_hi = 9'sd160;
    logic signed [8:0] thr_lo = 9'sd150;
    logic             cfg_shutdown = 1'b0;
    logic             cfg_mode = 1'b0;
    logic             cfg_polarity = 1'b0;
    logic [1:0]       cfg_queue = 2'b00;
    logic             rd_strobe = 1'b0;
    logic             alarm_pin, alarm_active;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ot_alarm dut_i (
        .clk(clk), .rst(rst), .conv_done(conv_done), .sample(sample),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .cfg_shutdown(cfg_shutdown),
        .cfg_mode(cfg_mode), .cfg_polarity(cfg_polarity), .cfg_queue(cfg_queue),
        .rd_strobe(rd_strobe), .alarm_pin(alarm_pin), .alarm_active(alarm_active)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_alarm, m_low, m_mode_prev;
    int m_run;
    int m_q_prev;

    function automatic int run_len(input int code);
        int lens[4] = '{1, 2, 4, 6};
        return lens[code];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_alarm = 0; m_low = 0; m_run = 0; m_mode_prev = 0; m_q_prev = 0;
        end else begin
            bit changed, wipe, hit, act;
            int t;
            changed = (cfg_mode != m_mode_prev) || (int'(cfg_queue) != m_q_prev);
            m_mode_prev = cfg_mode;
            m_q_prev = int'(cfg_queue);
            t = int'(sample);
            wipe = cfg_mode && m_alarm && (cfg_shutdown || rd_strobe);
            hit = (cfg_mode ? m_low : m_alarm) ? (t < int'(thr_lo)) : (t > int'(thr_hi));
            act = 0;
            if (cfg_shutdown || changed || (cfg_mode && m_alarm)) m_run = 0;
            else if (conv_done) begin
                if (hit) begin
                    m_run++;
                    if (m_run >= run_len(int'(cfg_queue))) begin m_run = 0; act = 1; end
                end else m_run = 0;
            end
            if (wipe) begin m_alarm = 0; m_low = !m_low; end
            else if (act) m_alarm = cfg_mode ? 1'b1 : !m_alarm;
            if (changed) m_low = 0;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(alarm_active, m_alarm, "R12 model state");
            chk(alarm_pin, cfg_polarity ? m_alarm : !m_alarm, "R8 model pin");
        end
    end

    task automatic cyc(input bit c, input int s, input bit r);
        conv_done = c;
        sample    = s[8:0];
        rd_strobe = r;
        @(negedge clk); #1;
        conv_done = 0;
        rd_strobe = 0;
    endtask

    task automatic idle();
        cyc(0, 0, 0);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1
        chk(alarm_active, 1'b0, "R1 reset state");
        chk(alarm_pin, 1'b1, "R1 reset pin");
        idle();

        // R4 thermostat, single fault, strict compares
        cyc(1, 160, 0); chk(alarm_active, 1'b0, "R4 equal to upper");
        cyc(1, 161, 0); chk(alarm_active, 1'b1, "R4 above upper");
        chk(alarm_pin, 1'b0, "R8 active low");
        cyc(1, 150, 0); chk(alarm_active, 1'b1, "R4 equal to lower");
        // R7
        cyc(0, 0, 1); chk(alarm_active, 1'b1, "R7 read ignored");
        cyc(1, 149, 0); chk(alarm_active, 1'b0, "R4 below lower");

        // R2 / R3 two faults
        cfg_queue = 2'b01; idle();
        cyc(1, 170, 0); cyc(1, 100, 0); cyc(1, 170, 0);
        chk(alarm_active, 1'b0, "R3 run broken");
        cyc(1, 170, 0); chk(alarm_active, 1'b1, "R2 two faults");
        cyc(1, 0, 0); cyc(1, 0, 0); chk(alarm_active, 1'b0, "R2 two lows");

        // R2 four faults
        cfg_queue = 2'b10; idle();
        for (int i = 0; i < 3; i++) cyc(1, 200, 0);
        chk(alarm_active, 1'b0, "R2 three of four");
        cyc(1, 200, 0); chk(alarm_active, 1'b1, "R2 four faults");
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);
        chk(alarm_active, 1'b0, "R3 restart after act");

        // R2 six faults
        cfg_queue = 2'b11; idle();
        for (int i = 0; i < 5; i++) cyc(1, 200, 0);
        chk(alarm_active, 1'b0, "R2 five of six");
        cyc(1, 200, 0); chk(alarm_active, 1'b1, "R2 six faults");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);

        // R4 signed thresholds
        cfg_queue = 2'b00; thr_hi = -9'sd10; thr_lo = -9'sd20; idle();
        cyc(1, -11, 0); chk(alarm_active, 1'b0, "R4 negative not above");
        cyc(1, -5, 0); chk(alarm_active, 1'b1, "R4 negative above");
        cyc(1, -25, 0); chk(alarm_active, 1'b0, "R4 negative below");
        thr_hi = 9'sd160; thr_lo = 9'sd150;

        // R5 / R6 latching
        cfg_mode = 1; idle();
        cyc(1, 170, 0); chk(alarm_active, 1'b1, "R5 latch set");
        cyc(1, 0, 0); cyc(1, 170, 0); chk(alarm_active, 1'b1, "R5 latch hold");
        cyc(0, 0, 1); chk(alarm_active, 1'b0, "R5 read clears");
        cyc(1, 170, 0); chk(alarm_active, 1'b0, "R6 upper disarmed");
        cyc(1, 155, 0); chk(alarm_active, 1'b0, "R6 between");
        cyc(1, 140, 0); chk(alarm_active, 1'b1, "R6 lower sets");
        cyc(0, 0, 1); cyc(1, 140, 0); chk(alarm_active, 1'b0, "R6 lower disarmed");
        cyc(1, 170, 0); chk(alarm_active, 1'b1, "R6 upper rearmed");

        // R11 read and sample together
        cyc(1, 140, 1); chk(alarm_active, 1'b0, "R11 read wins");
        cyc(1, 140, 0); chk(alarm_active, 1'b1, "R11 next sample counts");

        // R9 sleep in latching mode
        cfg_shutdown = 1; cyc(1, 140, 0); chk(alarm_active, 1'b0, "R9 sleep clears latch");
        cyc(1, 170, 0); chk(alarm_active, 1'b0, "R9 sample ignored asleep");
        cfg_shutdown = 0;
        cyc(1, 140, 0); chk(alarm_active, 1'b0, "R9 sleep toggled watch");
        cyc(1, 170, 0); chk(alarm_active, 1'b1, "R9 upper after sleep");

        // R9 sleep in thermostat mode, R10 config change with sample
        cfg_mode = 0; cyc(1, 0, 0); chk(alarm_active, 1'b1, "R10 change cycle ignored");
        cfg_shutdown = 1; cyc(1, 0, 0); chk(alarm_active, 1'b1, "R9 thermostat held");
        cfg_shutdown = 0; cyc(1, 0, 0); chk(alarm_active, 1'b0, "R9 awake lowers");

        // R10 run reset by queue change
        cfg_queue = 2'b01; idle();
        cyc(1, 170, 0); cfg_queue = 2'b00; idle(); cfg_queue = 2'b01; idle();
        cyc(1, 170, 0); chk(alarm_active, 1'b0, "R10 run wiped");
        cyc(1, 170, 0); chk(alarm_active, 1'b1, "R10 fresh run");
        cyc(1, 0, 0); cyc(1, 0, 0);

        // R10 watch direction reset by mode change
        cfg_queue = 2'b00; cfg_mode = 1; idle();
        cyc(1, 170, 0); cyc(0, 0, 1);
        cfg_mode = 0; idle(); cfg_mode = 1; idle();
        cyc(1, 140, 0); chk(alarm_active, 1'b0, "R10 lower not watched");
        cyc(1, 170, 0); chk(alarm_active, 1'b1, "R10 upper watched");

        // R8 active-high pin
        cfg_polarity = 1; #1;
        chk(alarm_pin, 1'b1, "R8 active high raised");
        cyc(0, 0, 1); chk(alarm_pin, 1'b0, "R8 active high cleared");
        idle();

        finish_up();
    end
endmodule